// File: doc/BRIEF.md
# Signed Multiply-Accumulate Long Unit

This block is a pipelined signed multiply-accumulate datapath with a 64-bit accumulator. Each request carries two word-sized source operands and an accumulator. The accumulator arrives as two separate words, a low word and a high word. The 64-bit result goes back out as a low word and a high word. A 2-bit mode input chooses among three product forms. The first is a full signed word-by-word product. The second is one signed halfword-by-halfword product, where each operand's halfword is picked independently. The third is the sum of two signed halfword products, paired either straight or crossed.

Decode, register-file access and condition evaluation all sit outside the block. The surrounding pipeline drives already-decoded mode and select bits. It also drives the two destination indices, so the unit can flag a request whose low and high destinations collide.

A request is accepted on a cycle where `start_i` and `ready_o` are both high. One request can be accepted per cycle. Stage 1 forms the product and stage 2 adds it to the accumulator. The registered result appears with `done_o` exactly two cycles after acceptance.

Top module: `smac_top`

## Requirements
- R1: With mode code 0, the result equals the accumulator plus the 64-bit signed product of `op_a_i` and `op_b_i`, each read as two's complement. A zero `op_a_i` returns the accumulator unchanged in every mode.
- R2: With mode code 1, `sel_a_i` picks the halfword of `op_a_i` and `sel_b_i` picks the halfword of `op_b_i` (0 = bits [15:0], 1 = bits [31:16]). The signed 16×16 product is sign-extended and added to the accumulator. The halfwords that are not selected do not change the result.
- R3: With mode code 2 and `swap_i` = 0, the result is the accumulator plus (top of a × top of b) plus (bottom of a × bottom of b). All halfwords are signed, and no precision is lost when every halfword is 0x8000.
- R4: With mode code 2 and `swap_i` = 1, the result is the accumulator plus (top of a × bottom of b) plus (bottom of a × top of b).
- R5: The accumulator input is `{acc_hi_i, acc_lo_i}` and the result is `{res_hi_o, res_lo_o}`; in each pair the low word holds bits [31:0] and the high word holds bits [63:32]. The sum wraps modulo 2^64 with no saturation.
- R6: `done_o` is high for one cycle exactly two cycles after each accepted request and at no other time. Requests accepted on back-to-back cycles complete on back-to-back cycles, in order.
- R7: `err_o` is high together with `done_o` when the request's `dst_lo_i` equals its `dst_hi_i`. Otherwise it is low.
- R8: While `rst` is high, `ready_o` is low. The cycle after reset, `done_o` and `err_o` are low.
- R9: `res_lo_o` and `res_hi_o` keep their last value on every cycle where `done_o` is low.
- R10: Mode code 3 produces the same result as mode code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request valid |
| ready_o | output | 1 | Unit can accept a request |
| mode_i | input | 2 | 0 word, 1 single halfword, 2 dual halfword, 3 as word |
| sel_a_i | input | 1 | Single mode: 1 selects top halfword of `op_a_i` |
| sel_b_i | input | 1 | Single mode: 1 selects top halfword of `op_b_i` |
| swap_i | input | 1 | Dual mode: crossed halfword pairing |
| op_a_i | input | DATA_W | First source operand |
| op_b_i | input | DATA_W | Second source operand |
| acc_lo_i | input | DATA_W | Accumulator bits [31:0] |
| acc_hi_i | input | DATA_W | Accumulator bits [63:32] |
| dst_lo_i | input | IDX_W | Destination index of the low word |
| dst_hi_i | input | IDX_W | Destination index of the high word |
| done_o | output | 1 | Result valid |
| res_lo_o | output | DATA_W | Result bits [31:0] |
| res_hi_o | output | DATA_W | Result bits [63:32] |
| err_o | output | 1 | Destinations of the completed request collide |

## Verification
The bench uses the defaults DATA_W = 32 and IDX_W = 4. At that width the extreme operands can be applied directly: 0x80000000 squared, halfwords of 0x8000 in every select and pairing, and accumulators one step from either 64-bit limit. These reach the carry into the high word, the 2^31 dual-mode sum and wrap-around. A 4-bit index gives equal and unequal destination pairs within a few vectors. Long runs of back-to-back requests, mixed with idle gaps, expose latency and ordering slips as well as result changes outside completions.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic [1:0] {
        SM_WORD = 2'd0,
        SM_HALF = 2'd1,
        SM_DUAL = 2'd2,
        SM_RSVD = 2'd3
    } smac_mode_e;

endpackage

// File: rtl/smac_lane_pick.sv
// Chooses the halfword pairs fed to the two halfword multipliers.
module smac_lane_pick
    import smac_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [1:0]                    mode_i,
    input  logic                          sel_a_i,
    input  logic                          sel_b_i,
    input  logic                          swap_i,
    input  logic [DATA_W-1:0]             op_a_i,
    input  logic [DATA_W-1:0]             op_b_i,
    output logic [1:0][HALF_W-1:0]        ha_o,
    output logic [1:0][HALF_W-1:0]        hb_o,
    output logic                          lane1_en_o
);
    logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;

    assign a_lo = op_a_i[HALF_W-1:0];
    assign a_hi = op_a_i[DATA_W-1:HALF_W];
    assign b_lo = op_b_i[HALF_W-1:0];
    assign b_hi = op_b_i[DATA_W-1:HALF_W];

    always_comb begin
        if (smac_mode_e'(mode_i) == SM_DUAL) begin
            ha_o[0]    = a_lo;
            hb_o[0]    = swap_i ? b_hi : b_lo;
            ha_o[1]    = a_hi;
            hb_o[1]    = swap_i ? b_lo : b_hi;
            lane1_en_o = 1'b1;
        end else begin
            ha_o[0]    = sel_a_i ? a_hi : a_lo;
            hb_o[0]    = sel_b_i ? b_hi : b_lo;
            ha_o[1]    = '0;
            hb_o[1]    = '0;
            lane1_en_o = 1'b0;
        end
    end
endmodule

// File: rtl/smac_product.sv
// Stage-1 product: full word product or sum of halfword lane products.
module smac_product
    import smac_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int ACC_W  = 2 * DATA_W
) (
    input  logic [1:0]                mode_i,
    input  logic [DATA_W-1:0]         op_a_i,
    input  logic [DATA_W-1:0]         op_b_i,
    input  logic [1:0][HALF_W-1:0]    ha_i,
    input  logic [1:0][HALF_W-1:0]    hb_i,
    input  logic                      lane1_en_i,
    output logic [ACC_W-1:0]          prod_o
);
    logic [ACC_W-1:0] wa_ext, wb_ext, word_prod;
    logic [1:0][ACC_W-1:0] lane_ext;
    logic [ACC_W-1:0] half_sum;

    // Sign-extend to the full width so the truncated product is the signed one.
    assign wa_ext    = {{DATA_W{op_a_i[DATA_W-1]}}, op_a_i};
    assign wb_ext    = {{DATA_W{op_b_i[DATA_W-1]}}, op_b_i};
    assign word_prod = wa_ext * wb_ext;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [DATA_W-1:0] xa, xb, p;
        assign xa = {{HALF_W{ha_i[g][HALF_W-1]}}, ha_i[g]};
        assign xb = {{HALF_W{hb_i[g][HALF_W-1]}}, hb_i[g]};
        assign p  = xa * xb;
        if (g == 0) begin : g_always
            assign lane_ext[g] = {{DATA_W{p[DATA_W-1]}}, p};
        end else begin : g_gated
            assign lane_ext[g] = lane1_en_i ? {{DATA_W{p[DATA_W-1]}}, p} : '0;
        end
    end

    // Summed at full width: two most-negative lane products cannot overflow.
    assign half_sum = lane_ext[0] + lane_ext[1];

    always_comb begin
        unique case (smac_mode_e'(mode_i))
            SM_HALF, SM_DUAL: prod_o = half_sum;
            default:          prod_o = word_prod;
        endcase
    end
endmodule

// File: rtl/smac_accum.sv
// Stage-2 accumulate, modulo 2^ACC_W.
module smac_accum #(
    parameter int DATA_W = 32,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic [ACC_W-1:0] prod_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] sum_o
);
    assign sum_o = prod_i + acc_i;
endmodule

// File: rtl/smac_top.sv
module smac_top #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              ready_o,
    input  logic [1:0]        mode_i,
    input  logic              sel_a_i,
    input  logic              sel_b_i,
    input  logic              swap_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [DATA_W-1:0] acc_lo_i,
    input  logic [DATA_W-1:0] acc_hi_i,
    input  logic [IDX_W-1:0]  dst_lo_i,
    input  logic [IDX_W-1:0]  dst_hi_i,
    output logic              done_o,
    output logic [DATA_W-1:0] res_lo_o,
    output logic [DATA_W-1:0] res_hi_o,
    output logic              err_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W;

    typedef struct packed {
        logic             s1_vld;
        logic [ACC_W-1:0] s1_prod;
        logic [ACC_W-1:0] s1_acc;
        logic             s1_err;
        logic             s2_vld;
        logic [ACC_W-1:0] s2_res;
        logic             s2_err;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [1:0][HALF_W-1:0] ha_w, hb_w;
    logic                   lane1_en_w;
    logic [ACC_W-1:0]       prod_w, sum_w;
    logic                   accept_w;

    smac_lane_pick #(.DATA_W(DATA_W)) u_pick (
        .mode_i     (mode_i),
        .sel_a_i    (sel_a_i),
        .sel_b_i    (sel_b_i),
        .swap_i     (swap_i),
        .op_a_i     (op_a_i),
        .op_b_i     (op_b_i),
        .ha_o       (ha_w),
        .hb_o       (hb_w),
        .lane1_en_o (lane1_en_w)
    );

    smac_product #(.DATA_W(DATA_W)) u_prod (
        .mode_i     (mode_i),
        .op_a_i     (op_a_i),
        .op_b_i     (op_b_i),
        .ha_i       (ha_w),
        .hb_i       (hb_w),
        .lane1_en_i (lane1_en_w),
        .prod_o     (prod_w)
    );

    smac_accum #(.DATA_W(DATA_W)) u_acc (
        .prod_i (pipe_q.s1_prod),
        .acc_i  (pipe_q.s1_acc),
        .sum_o  (sum_w)
    );

    assign ready_o  = ~rst;
    assign accept_w = start_i & ready_o;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1_vld = accept_w;
        if (accept_w) begin
            pipe_d.s1_prod = prod_w;
            pipe_d.s1_acc  = {acc_hi_i, acc_lo_i};
            pipe_d.s1_err  = (dst_lo_i == dst_hi_i);
        end
        pipe_d.s2_vld = pipe_q.s1_vld;
        if (pipe_q.s1_vld) begin
            pipe_d.s2_res = sum_w;
            pipe_d.s2_err = pipe_q.s1_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign done_o   = pipe_q.s2_vld;
    assign err_o    = pipe_q.s2_vld & pipe_q.s2_err;
    assign res_lo_o = pipe_q.s2_res[DATA_W-1:0];
    assign res_hi_o = pipe_q.s2_res[ACC_W-1:DATA_W];
endmodule

// File: rtl/smac_chk.sv
module smac_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              ready_o,
    input logic [DATA_W-1:0] op_a_i,
    input logic [DATA_W-1:0] acc_lo_i,
    input logic [DATA_W-1:0] acc_hi_i,
    input logic [IDX_W-1:0]  dst_lo_i,
    input logic [IDX_W-1:0]  dst_hi_i,
    input logic              done_o,
    input logic [DATA_W-1:0] res_lo_o,
    input logic [DATA_W-1:0] res_hi_o,
    input logic              err_o
);
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o) |=> ##1 done_o); // R6
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i && ready_o, 2)); // R6
    AST_ERR_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o && dst_lo_i == dst_hi_i) |=> ##1 err_o); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({res_hi_o, res_lo_o})); // R9
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o && op_a_i == '0) |=> ##1
        ({res_hi_o, res_lo_o} == $past({acc_hi_i, acc_lo_i}, 2))); // R1
    AST_RESET_BUSY: assert property (@(posedge clk)
        rst |-> !ready_o); // R8
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!done_o && !err_o)); // R8
endmodule

bind smac_top smac_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .ready_o  (ready_o),
    .op_a_i   (op_a_i),
    .acc_lo_i (acc_lo_i),
    .acc_hi_i (acc_hi_i),
    .dst_lo_i (dst_lo_i),
    .dst_hi_i (dst_hi_i),
    .done_o   (done_o),
    .res_lo_o (res_lo_o),
    .res_hi_o (res_hi_o),
    .err_o    (err_o)
);

// File: tb/sim_smac_top.sv
`timescale 1ns/1ps
module sim_smac_top;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          ready_o;
    logic [1:0]    mode_i = '0;
    logic          sel_a_i = 1'b0, sel_b_i = 1'b0, swap_i = 1'b0;
    logic [DW-1:0] op_a_i = '0, op_b_i = '0, acc_lo_i = '0, acc_hi_i = '0;
    logic [IW-1:0] dst_lo_i = '0, dst_hi_i = 4'd1;
    logic          done_o, err_o;
    logic [DW-1:0] res_lo_o, res_hi_o;

    always #2.5 clk = ~clk;

    smac_top #(.DATA_W(DW), .IDX_W(IW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .ready_o(ready_o),
        .mode_i(mode_i), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .swap_i(swap_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i),
        .dst_lo_i(dst_lo_i), .dst_hi_i(dst_hi_i), .done_o(done_o),
        .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .err_o(err_o)
    );

    typedef struct {
        logic [63:0] res;
        logic        err;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_calc(input logic [1:0] m, input bit sa, input bit sb,
                                             input bit sw, input logic [31:0] a,
                                             input logic [31:0] b, input logic [63:0] acc);
        longint p;
        shortint ah, al, bh, bl;
        ah = a[31:16]; al = a[15:0]; bh = b[31:16]; bl = b[15:0];
        case (m)
            2'd1:    p = longint'(sa ? ah : al) * longint'(sb ? bh : bl);
            2'd2:    p = sw ? (longint'(ah) * longint'(bl) + longint'(al) * longint'(bh))
                            : (longint'(ah) * longint'(bh) + longint'(al) * longint'(bl));
            default: p = longint'(int'(a)) * longint'(int'(b));
        endcase
        return acc + 64'(p);
    endfunction

    // Driver: presents one request for one cycle, starting at a negedge.
    task automatic send(input string tag, input logic [1:0] m, input bit sa, input bit sb,
                        input bit sw, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] acc, input logic [3:0] dl, input logic [3:0] dh);
        exp_t e;
        start_i = 1'b1; mode_i = m; sel_a_i = sa; sel_b_i = sb; swap_i = sw;
        op_a_i = a; op_b_i = b; acc_lo_i = acc[31:0]; acc_hi_i = acc[63:32];
        dst_lo_i = dl; dst_hi_i = dh;
        e.res = ref_calc(m, sa, sb, sw, a, b, acc);
        e.err = (dl == dh);
        e.due = cyc + 2;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = 32'hDEAD_BEEF; op_b_i = 32'h1357_9BDF;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops and compares at each completion.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R6", "done without request", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({res_hi_o, res_lo_o} == e.res, e.tag, "result",
                      {res_hi_o, res_lo_o}, e.res);
                check(err_o == e.err, "R7", "err flag", 64'(err_o), 64'(e.err));
                check(cyc == e.due, "R6", "latency cycle", 64'(cyc), 64'(e.due));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [63:0] held;
        @(negedge clk);
        check(ready_o == 1'b0, "R8", "ready in reset", 64'(ready_o), 64'd0);
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0 && err_o == 1'b0, "R8", "idle after reset",
              64'({done_o, err_o}), 64'd0);
        check(ready_o == 1'b1, "R8", "ready after reset", 64'(ready_o), 64'd1);

        // R1 word mode corners
        send("R1", 2'd0, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 64'd0, 4'd0, 4'd1);
        send("R1", 2'd0, 0, 0, 0, 32'hFFFF_FFFF, 32'd5, 64'd10, 4'd2, 4'd3);
        send("R1", 2'd0, 0, 0, 0, 32'h7FFF_FFFF, 32'h8000_0000, 64'h1234_5678_9ABC_DEF0, 4'd4, 4'd5);
        send("R1", 2'd2, 0, 0, 1, 32'd0, 32'h8000_8000, 64'h8765_4321_0FED_CBA9, 4'd1, 4'd0);
        // R5 wrap and word split
        send("R5", 2'd0, 0, 0, 0, 32'd1, 32'd1, 64'h7FFF_FFFF_FFFF_FFFF, 4'd0, 4'd1);
        send("R5", 2'd0, 0, 0, 0, 32'd1, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 4'd1);
        send("R5", 2'd0, 0, 0, 0, 32'hFFFF_FFFF, 32'd1, 64'h8000_0000_0000_0000, 4'd0, 4'd1);
        send("R5", 2'd1, 0, 0, 0, 32'd1, 32'd1, 64'h0000_0000_FFFF_FFFF, 4'd0, 4'd1);
        idle(3);
        // R2 all select combinations, 0x8000 halves
        for (int s = 0; s < 4; s++) begin
            send("R2", 2'd1, s[1], s[0], 0, 32'h8000_7FFF, 32'h8000_0003, 64'h0000_0001_0000_0000, 4'd3, 4'd9);
        end
        send("R2", 2'd1, 1, 1, 0, 32'h8000_8000, 32'h8000_8000, 64'd0, 4'd3, 4'd9);
        // R2 unselected halves differ: same expected
        send("R2", 2'd1, 0, 1, 0, 32'h1111_FFFE, 32'h0007_2222, 64'd100, 4'd3, 4'd9);
        send("R2", 2'd1, 0, 1, 0, 32'hEEEE_FFFE, 32'h0007_DDDD, 64'd100, 4'd3, 4'd9);
        idle(2);
        // R3 / R4 dual
        send("R3", 2'd2, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 64'd0, 4'd6, 4'd7);
        send("R3", 2'd2, 0, 0, 0, 32'h0003_FFFE, 32'h0005_0007, 64'hFFFF_FFFF_FFFF_FFF0, 4'd6, 4'd7);
        send("R4", 2'd2, 0, 0, 1, 32'h8000_8000, 32'h8000_8000, 64'h7FFF_FFFF_0000_0000, 4'd6, 4'd7);
        send("R4", 2'd2, 0, 0, 1, 32'h0003_FFFE, 32'h0005_0007, 64'd0, 4'd6, 4'd7);
        // R10 reserved code as word mode
        send("R10", 2'd3, 1, 1, 1, 32'h8000_0000, 32'h8000_0000, 64'd7, 4'd1, 4'd2);
        send("R10", 2'd3, 0, 1, 0, 32'hFFFF_0002, 32'h0001_FFFF, 64'd0, 4'd1, 4'd2);
        // R7 destination collision
        send("R7", 2'd0, 0, 0, 0, 32'd3, 32'd4, 64'd0, 4'd5, 4'd5);
        send("R7", 2'd1, 0, 0, 0, 32'd3, 32'd4, 64'd0, 4'd15, 4'd15);
        idle(3);
        // R9 hold across idle cycles
        held = {res_hi_o, res_lo_o};
        idle(4);
        check({res_hi_o, res_lo_o} == held, "R9", "hold while idle", {res_hi_o, res_lo_o}, held);

        // Mixed back-to-back and gapped traffic (R6 ordering)
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a, b;
            logic [63:0] acc;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} * 32'd1664525 + 32'd1013904223;
            a = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            b = lfsr;
            acc = {a ^ b, b + a};
            send("R6", lfsr[5:4], lfsr[6], lfsr[7], lfsr[8], a, b, acc, lfsr[11:8], lfsr[15:12]);
            if (lfsr[20]) idle(int'(lfsr[22:21]));
        end
        idle(4);
        check(q.size() == 0, "R6", "all requests completed", 64'(q.size()), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule